// File: doc/BRIEF.md
# Interrupt Flag and Mask Unit

This block is the interrupt front end of a small microcontroller. It watches three sources: a single external interrupt pin, an input port whose every bit is monitored for changes, and a one-cycle overflow pulse from a timer. Each source has a pending flag and an enable bit. These sit in four byte-wide registers on a simple register bus made of an address, a write strobe, write data and combinational read data.

A pending source raises a request only when its own enable bit and the global interrupt enable are both set. When several sources qualify, a fixed priority picks one and presents its vector number to the CPU. The CPU pulses an acknowledge to clear the flag of the presented source. Software can also clear any flag by writing a one to its bit. The external pin has four sensing modes. In the low-level mode the pin level drives the request directly and the pin's flag is held at zero. Pin and port inputs are asynchronous and pass through a two-stage synchronizer before any detection.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset every register reads 0x00, `irq_req` is low and `irq_vec` is 0.
- R2: Only these bits exist: mask register 0x3B bits 6 (external enable) and 5 (pin-change enable), flag register 0x3A bits 6 (external flag) and 5 (pin-change flag), timer mask 0x39 bit 1 and timer flag 0x38 bit 1. All other bits read zero and ignore writes. Any other address reads 0x00.
- R3: With `sense_mode` 2'b11 a rising edge sets the external flag, with 2'b10 a falling edge sets it, and with 2'b01 either edge sets it. An edge of the wrong direction leaves the flag clear.
- R4: With `sense_mode` 2'b00 the external flag reads zero. The external source requests while the synchronized pin is low.
- R5: A change in either direction on any bit of `port_in` sets the pin-change flag.
- R6: A high cycle on `ovf_pulse` sets the timer flag in the next cycle.
- R7: Writing a one to a flag bit clears it. Writing zero leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R8: `irq_req` is high only when some source has its flag (or low level) together with its enable bit, and `glob_en` is high.
- R9: `irq_vec` is 1 for the external source, 2 for pin change and 3 for the timer. The lowest qualifying number wins. The value is 0 when no request is raised.
- R10: A high cycle on `irq_ack` while a request is raised clears the flag of the presented vector only.
- R11: A change on `ext_pin` or `port_in` is visible in the flag register after the third rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 1 | External interrupt pin (pad value, asynchronous) |
| port_in | input | PORT_W | Monitored input port (asynchronous) |
| ovf_pulse | input | 1 | Timer overflow, one cycle per event, synchronous |
| sense_mode | input | 2 | External pin sensing: 00 low level, 01 any edge, 10 falling, 11 rising |
| glob_en | input | 1 | Global interrupt enable from the CPU status |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 2 | Vector number of the selected source, 0 when none |
| irq_ack | input | 1 | Acknowledge of the presented vector |

## Verification
A flag that is stuck or lost shows at the ports in the next cycle. It appears in the read data of its flag register and in `irq_req` and `irq_vec` once its enable and the global enable are set. A wrong synchronizer depth or a wrong edge-history register moves the flag by one cycle against the three-edge latency, or sets it on an edge of the wrong direction. The directed tests sample the flags at the second and third edge after each change for that reason. A wrong priority or acknowledge decode shows as a wrong vector sequence while three sources are pending and acknowledged one by one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;
  localparam int NSRC  = 3;
  localparam int VEC_W = $clog2(NSRC + 1);

  localparam logic [5:0] ADR_PMASK = 6'h3B;
  localparam logic [5:0] ADR_PFLAG = 6'h3A;
  localparam logic [5:0] ADR_TMASK = 6'h39;
  localparam logic [5:0] ADR_TFLAG = 6'h38;

  localparam int EXT_BIT = 6;
  localparam int PC_BIT  = 5;
  localparam int OVF_BIT = 1;

  localparam logic [REG_W-1:0] PIN_BITS = REG_W'((1 << EXT_BIT) | (1 << PC_BIT));
  localparam logic [REG_W-1:0] TMR_BITS = REG_W'(1 << OVF_BIT);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  function automatic logic [REG_W-1:0] flag_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] set,
    input logic [REG_W-1:0] clr,
    input logic [REG_W-1:0] keep
  );
    return ((cur & ~clr) | set) & keep;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = level;
    rise   = level & ~prev_q;
    fall   = ~level & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 3,
  parameter int VEC_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) vec = VEC_W'(i + 1);
    end
    any = |req;
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic              ovf_pulse,
  input  logic [1:0]        sense_mode,
  input  logic              glob_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_req,
  output logic [1:0]        irq_vec,
  input  logic              irq_ack
);
  localparam int IN_W = PORT_W + 1;

  logic            rst_s_n;
  logic [IN_W-1:0] in_sync;
  logic [IN_W-1:0] in_rise;
  logic [IN_W-1:0] in_fall;
  sense_e          mode;

  logic ext_lvl, ext_evt, pc_evt;

  logic [REG_W-1:0] pmask_q, pmask_d, pflag_q, pflag_d;
  logic [REG_W-1:0] tmask_q, tmask_d, tflag_q, tflag_d;
  logic [REG_W-1:0] pflag_set, pflag_clr, tflag_set, tflag_clr;
  logic             pmask_en, tmask_en, pflag_en, tflag_en;
  logic             wr_pmask, wr_pflag, wr_tmask, wr_tflag;

  logic [NSRC-1:0]  src_req;
  logic             sel_any;
  logic [VEC_W-1:0] sel_vec;
  logic             ack_ext, ack_pc, ack_ovf;
  logic             ext_src;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  irq_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .din  ({port_in, ext_pin}),
    .dout (in_sync)
  );

  irq_sense #(.W(IN_W)) u_sense (
    .clk  (clk),
    .rst_n(rst_s_n),
    .level(in_sync),
    .rise (in_rise),
    .fall (in_fall)
  );

  // External pin event by sensing mode; port change in any direction
  always_comb begin
    mode    = sense_e'(sense_mode);
    ext_lvl = in_sync[0];
    unique case (mode)
      SENSE_ANY:  ext_evt = in_rise[0] | in_fall[0];
      SENSE_FALL: ext_evt = in_fall[0];
      SENSE_RISE: ext_evt = in_rise[0];
      default:    ext_evt = 1'b0;
    endcase
    pc_evt = |(in_rise[IN_W-1:1] | in_fall[IN_W-1:1]);
  end

  // Register bus decode
  always_comb begin
    wr_pmask = reg_we && (reg_addr == ADDR_W'(ADR_PMASK));
    wr_pflag = reg_we && (reg_addr == ADDR_W'(ADR_PFLAG));
    wr_tmask = reg_we && (reg_addr == ADDR_W'(ADR_TMASK));
    wr_tflag = reg_we && (reg_addr == ADDR_W'(ADR_TFLAG));
  end

  // Source gating and priority
  always_comb begin
    ext_src = (mode == SENSE_LOW) ? ~ext_lvl : pflag_q[EXT_BIT];
    src_req[0] = glob_en & pmask_q[EXT_BIT] & ext_src;
    src_req[1] = glob_en & pmask_q[PC_BIT]  & pflag_q[PC_BIT];
    src_req[2] = glob_en & tmask_q[OVF_BIT] & tflag_q[OVF_BIT];
  end

  irq_prio #(.N(NSRC), .VEC_W(VEC_W)) u_prio (
    .req(src_req),
    .any(sel_any),
    .vec(sel_vec)
  );

  assign irq_req = sel_any;
  assign irq_vec = sel_vec;

  // Next-state for mask and flag registers
  always_comb begin
    ack_ext = irq_ack && sel_any && (sel_vec == VEC_W'(1));
    ack_pc  = irq_ack && sel_any && (sel_vec == VEC_W'(2));
    ack_ovf = irq_ack && sel_any && (sel_vec == VEC_W'(3));

    pmask_en = wr_pmask;
    pmask_d  = reg_wdata & PIN_BITS;
    tmask_en = wr_tmask;
    tmask_d  = reg_wdata & TMR_BITS;

    pflag_set = '0;
    pflag_set[EXT_BIT] = ext_evt;
    pflag_set[PC_BIT]  = pc_evt;
    pflag_clr = wr_pflag ? reg_wdata : '0;
    pflag_clr[EXT_BIT] = pflag_clr[EXT_BIT] | ack_ext | (mode == SENSE_LOW);
    pflag_clr[PC_BIT]  = pflag_clr[PC_BIT]  | ack_pc;
    pflag_en = |((pflag_set | pflag_clr) & PIN_BITS);
    pflag_d  = flag_next(pflag_q, pflag_set, pflag_clr, PIN_BITS);
    if (mode == SENSE_LOW) pflag_d[EXT_BIT] = 1'b0;

    tflag_set = '0;
    tflag_set[OVF_BIT] = ovf_pulse;
    tflag_clr = wr_tflag ? reg_wdata : '0;
    tflag_clr[OVF_BIT] = tflag_clr[OVF_BIT] | ack_ovf;
    tflag_en = |((tflag_set | tflag_clr) & TMR_BITS);
    tflag_d  = flag_next(tflag_q, tflag_set, tflag_clr, TMR_BITS);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pmask_q <= '0;
      tmask_q <= '0;
      pflag_q <= '0;
      tflag_q <= '0;
    end else begin
      if (pmask_en) pmask_q <= pmask_d;
      if (tmask_en) tmask_q <= tmask_d;
      if (pflag_en) pflag_q <= pflag_d;
      if (tflag_en) tflag_q <= tflag_d;
    end
  end

  // Read mux
  always_comb begin
    if      (reg_addr == ADDR_W'(ADR_PMASK)) reg_rdata = pmask_q;
    else if (reg_addr == ADDR_W'(ADR_PFLAG)) reg_rdata = pflag_q;
    else if (reg_addr == ADDR_W'(ADR_TMASK)) reg_rdata = tmask_q;
    else if (reg_addr == ADDR_W'(ADR_TFLAG)) reg_rdata = tflag_q;
    else                                     reg_rdata = '0;
  end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glob_en,
  input logic       irq_req,
  input logic [1:0] irq_vec,
  input logic       irq_ack,
  input logic [1:0] sense_mode,
  input logic       ovf_pulse,
  input logic       ext_flag,
  input logic       ovf_flag
);
  AST_NO_REQ_WITHOUT_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_req); // R8

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 2'd0)); // R9

  AST_REQ_HAS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec != 2'd0)); // R9

  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode == 2'b00) |=> !ext_flag); // R4

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> ovf_flag); // R6

  AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == 2'd3 && !ovf_pulse) |=> !ovf_flag); // R10
endmodule

bind irq_flag_unit irq_flag_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .glob_en   (glob_en),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .irq_ack   (irq_ack),
  .sense_mode(sense_mode),
  .ovf_pulse (ovf_pulse),
  .ext_flag  (pflag_q[6]),
  .ovf_flag  (tflag_q[1])
);

// File: tb/irq_flag_unit_test.sv
module irq_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin;
  logic [7:0] port_in;
  logic       ovf_pulse;
  logic [1:0] sense_mode;
  logic       glob_en;
  logic [5:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [1:0] irq_vec;
  logic       irq_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .ovf_pulse(ovf_pulse), .sense_mode(sense_mode), .glob_en(glob_en),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_ovf();
    ovf_pulse = 1'b1;
    @(negedge clk);
    ovf_pulse = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rd_chk("R1 mask", 6'h3B, 8'h00);
    rd_chk("R1 pflag", 6'h3A, 8'h00);
    rd_chk("R1 tmask", 6'h39, 8'h00);
    rd_chk("R1 tflag", 6'h38, 8'h00);
    chk("R1 req", irq_req, 0);
    chk("R1 vec", irq_vec, 0);
  endtask

  task automatic t_reserved();
    wr(6'h3B, 8'hFF); rd_chk("R2 mask bits", 6'h3B, 8'h60);
    wr(6'h39, 8'hFF); rd_chk("R2 tmask bits", 6'h39, 8'h02);
    wr(6'h3A, 8'hFF); rd_chk("R2 pflag bits", 6'h3A, 8'h00);
    wr(6'h10, 8'hFF); rd_chk("R2 unmapped", 6'h10, 8'h00);
    wr(6'h3B, 8'h00); wr(6'h39, 8'h00);
    rd_chk("R2 mask cleared", 6'h3B, 8'h00);
  endtask

  task automatic t_edges();
    sense_mode = 2'b11;
    ext_pin = 1'b1;
    wait_n(2); rd_chk("R11 not yet after 2 edges", 6'h3A, 8'h00);
    wait_n(1); rd_chk("R11 R3 rise sets after 3 edges", 6'h3A, 8'h40);
    wr(6'h3A, 8'h40); rd_chk("R7 w1c ext", 6'h3A, 8'h00);
    sense_mode = 2'b10;
    ext_pin = 1'b0; wait_n(4);
    rd_chk("R3 fall sets", 6'h3A, 8'h40);
    wr(6'h3A, 8'h40);
    ext_pin = 1'b1; wait_n(4);
    rd_chk("R3 rise ignored in fall mode", 6'h3A, 8'h00);
    sense_mode = 2'b01;
    ext_pin = 1'b0; wait_n(4);
    rd_chk("R3 any edge fall", 6'h3A, 8'h40);
    wr(6'h3A, 8'h40);
    ext_pin = 1'b1; wait_n(4);
    rd_chk("R3 any edge rise", 6'h3A, 8'h40);
    wr(6'h3A, 8'h00); rd_chk("R7 zero write keeps", 6'h3A, 8'h40);
    wr(6'h3A, 8'h40); rd_chk("R7 cleared", 6'h3A, 8'h00);
  endtask

  task automatic t_level();
    wr(6'h3B, 8'h40);
    glob_en = 1'b1;
    sense_mode = 2'b00;
    wait_n(1);
    chk("R4 high pin no request", irq_req, 0);
    ext_pin = 1'b0; wait_n(3);
    chk("R4 low pin requests", irq_req, 1);
    chk("R4 vec", irq_vec, 1);
    rd_chk("R4 flag reads zero", 6'h3A, 8'h00);
    ext_pin = 1'b1; wait_n(3);
    chk("R4 request drops", irq_req, 0);
    glob_en = 1'b0;
    wr(6'h3B, 8'h00);
    sense_mode = 2'b11;
    wait_n(1);
    rd_chk("R4 no stray flag", 6'h3A, 8'h00);
  endtask

  task automatic t_pinchg();
    port_in = 8'h08; wait_n(3);
    rd_chk("R5 rise bit3", 6'h3A, 8'h20);
    wr(6'h3A, 8'h20);
    port_in = 8'h00; wait_n(4);
    rd_chk("R5 fall bit3", 6'h3A, 8'h20);
    wr(6'h3A, 8'h20);
    port_in = 8'h81; wait_n(4);
    rd_chk("R5 two bits", 6'h3A, 8'h20);
    wr(6'h3A, 8'h20);
    rd_chk("R7 pc w1c", 6'h3A, 8'h00);
  endtask

  task automatic t_ovf();
    pulse_ovf(); #1;
    rd_chk("R6 ovf sets", 6'h38, 8'h02);
    wr(6'h38, 8'h00); rd_chk("R7 zero write keeps ovf", 6'h38, 8'h02);
    wr(6'h38, 8'h02); rd_chk("R7 ovf w1c", 6'h38, 8'h00);
    ovf_pulse = 1'b1;
    wr(6'h38, 8'h02);
    ovf_pulse = 1'b0;
    rd_chk("R7 set wins over clear", 6'h38, 8'h02);
    wr(6'h38, 8'h02);
  endtask

  task automatic t_gate();
    pulse_ovf();
    glob_en = 1'b1; #1;
    chk("R8 mask off", irq_req, 0);
    glob_en = 1'b0;
    wr(6'h39, 8'h02); #1;
    chk("R8 global off", irq_req, 0);
    glob_en = 1'b1; #1;
    chk("R8 both on", irq_req, 1);
    chk("R9 timer vec", irq_vec, 3);
    glob_en = 1'b0;
    wr(6'h38, 8'h02);
  endtask

  task automatic t_prio();
    sense_mode = 2'b10;
    ext_pin = 1'b0;
    port_in = 8'h80;
    wait_n(4);
    pulse_ovf();
    wr(6'h3B, 8'h60); wr(6'h39, 8'h02);
    glob_en = 1'b1; #1;
    chk("R9 ext first", irq_vec, 1);
    pulse_ack();
    chk("R10 then pin change", irq_vec, 2);
    rd_chk("R10 only ext cleared", 6'h3A, 8'h20);
    pulse_ack();
    chk("R10 then timer", irq_vec, 3);
    pulse_ack();
    chk("R10 none left", irq_req, 0);
    rd_chk("R10 timer cleared", 6'h38, 8'h00);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_pin = 1'b0; port_in = '0; ovf_pulse = 1'b0;
    sense_mode = 2'b11; glob_en = 1'b0; reg_addr = '0; reg_we = 1'b0;
    reg_wdata = '0; irq_ack = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_reserved();
    t_edges();
    t_level();
    t_pinchg();
    t_ovf();
    t_gate();
    t_prio();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule